// File: doc/BRIEF.md
# Variable-Length Instruction Word Assembler

This block takes a stream of 16-bit instruction words through a valid/ready handshake and groups them into complete instructions. It looks at the first word of each instruction and works out its format class and its addressing modes. From these it knows how many extension words follow: none, one or two. It gathers those words and presents one record per instruction on a registered output with its own valid/ready handshake.

Each record carries:
- the first word and the length in words;
- the format class and the register and mode fields;
- the generated constant for constant-generator sources;
- the jump condition and the sign-extended jump offset;
- the extension words and an error flag.

An encoding with an invalid source mode produces a one-word error record, and decoding restarts at the next word. A flush input ends a stream early. When flush arrives while the oldest instruction still lacks extension words, that instruction's first word leaves as a one-word error record. The words already gathered behind it are then decoded again as new instruction starts.

The block holds at most three words internally. Records leave in input order, at most one per clock.

Top module: `insn_word_assembler`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, the partial-instruction state and `out_valid` are cleared. After the reset, `in_ready` is 1 and no word received before the reset takes part in any later record.
- R2: Bits 15:13 of the first word select the class.
  - 0 gives `out_fmt`=0 (single operand).
  - 1 gives `out_fmt`=1 (jump).
  - Any other value gives `out_fmt`=2 (two operand).
  - In class 2 the source register is bits 11:8 and the destination register is bits 3:0. In class 0 the operand register (reported as source) is bits 3:0. Unused register fields read 0.
- R3: The source mode (As = bits 5:4) is reported on `out_src_mode` with these codes:
  - register 0, indexed 1, indirect 2, post-increment 3, symbolic 4, immediate 5, absolute 6, constant 7, invalid 15.
  - Register 0 with As=1, 2 or 3 gives 4, 15 or 5.
  - Register 2 with As=1 gives 6, and with As=2 or 3 gives 7.
  - Register 3 always gives 7.
  - Every other case gives code = As.
  - Jump records report 0.
- R4: In class 2, bit 7 selects the destination mode on `out_dst_mode`.
  - 0 gives register mode (0).
  - 1 gives symbolic (4) for register 0, absolute (6) for register 2, and indexed (1) for any other register.
  - Classes 0 and 1 report 0.
- R5: A constant source sets `out_cg_hit` and `out_cg_val`, and `out_cg_hit` is set only for constant sources.
  - Register 2 gives 4 for As=2 and 8 for As=3.
  - Register 3 gives 0, 1, 2 and 0xFFFF for As=0..3.
  - Otherwise `out_cg_val` is 0.
- R6: Length and extension words:
  - A source in mode 1, 4, 5 or 6 adds one extension word.
  - A class-2 destination in mode 1, 4 or 6 adds one more.
  - `out_len` is 1 to 3.
  - `out_ext0` is the second word of the instruction and `out_ext1` the third. The source's extension comes first.
  - Unused extension fields read 0.
  - No record is produced while required words are missing and flush is low.
- R7: A class-1 word is always a one-word record without error.
  - `out_cond` is bits 12:10.
  - `out_offset` is bits 9:0 sign-extended to 16 bits.
- R8: A first word whose source mode is invalid (15) yields a record with `out_err`=1 and `out_len`=1. Only that word is consumed, and the next word starts a new instruction.
- R9: When `in_flush` is high and the oldest instruction lacks extension words, a record with `out_err`=1 and `out_len`=1 is emitted for its first word. The remaining buffered words are decoded again as instruction starts. Flush with an empty buffer emits nothing.
- R10: Hand-off behaviour:
  - While `out_valid` is high and `out_ready` is low, the record is held unchanged.
  - `in_ready` is low while three words are buffered or `in_flush` is high.
  - No accepted word is lost or duplicated under any stall pattern.
- R11: Records leave in input order, at most one per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can take a word |
| in_word | input | 16 | Instruction word |
| in_flush | input | 1 | End of stream: give up on incomplete instructions |
| out_valid | output | 1 | Record valid |
| out_ready | input | 1 | Consumer takes the record |
| out_word | output | 16 | First word of the instruction |
| out_len | output | 2 | Length in words (1 to 3) |
| out_err | output | 1 | Invalid or truncated encoding |
| out_fmt | output | 2 | Format class |
| out_src_reg | output | 4 | Source (or single operand) register |
| out_src_mode | output | 4 | Source mode code |
| out_dst_reg | output | 4 | Destination register |
| out_dst_mode | output | 4 | Destination mode code |
| out_cg_hit | output | 1 | Source is a generated constant |
| out_cg_val | output | 16 | Generated constant value |
| out_cond | output | 3 | Jump condition code |
| out_offset | output | 16 | Sign-extended jump word offset |
| out_ext0 | output | 16 | First extension word |
| out_ext1 | output | 16 | Second extension word |

## Verification
The bench sweeps every source register and source mode against both destination mode values, several destination registers and all two-operand class codes. It also sweeps every single-operand register and mode, and every jump condition with offsets at the sign boundary. A decoder that mixed up registers 0, 2 and 3 would get the length wrong and desynchronise the whole remaining stream, and the bench would see every later record shifted. Flush is applied with one or two words short, with replayed words that are themselves incomplete or are jumps, and with an empty buffer. A design that dropped the buffered words, or consumed more than one word on error, would emit the wrong next record. Input gaps and output stalls vary across the run, so a held record that changed or a word taken twice shows up as a mismatch.

// File: rtl/iwa_pkg.sv
// Shared constants and types of the instruction word assembler.
// Assumes a fixed 16-bit encoding with at most two extension words.
package iwa_pkg;
    localparam int WORD_W    = 16;
    localparam int MAX_WORDS = 3;
    localparam int CNT_W     = $clog2(MAX_WORDS + 1);
    localparam int JOFF_W    = 10;

    typedef enum logic [1:0] {
        FMT_ONE = 2'd0,
        FMT_JMP = 2'd1,
        FMT_TWO = 2'd2
    } fmt_e;

    typedef enum logic [3:0] {
        AM_REG  = 4'd0,
        AM_IDX  = 4'd1,
        AM_IND  = 4'd2,
        AM_POST = 4'd3,
        AM_SYM  = 4'd4,
        AM_IMM  = 4'd5,
        AM_ABS  = 4'd6,
        AM_CGEN = 4'd7,
        AM_BAD  = 4'd15
    } amode_e;

    typedef struct packed {
        fmt_e              fmt;
        logic              bad;
        logic [1:0]        len;
        logic [3:0]        src_reg;
        logic [3:0]        dst_reg;
        amode_e            src_mode;
        amode_e            dst_mode;
        logic              cg_hit;
        logic [WORD_W-1:0] cg_val;
        logic [2:0]        cond;
        logic [WORD_W-1:0] offset;
    } dec_t;
endpackage

// File: rtl/iwa_src_mode.sv
// Source operand mode decoder.
// Maps register number and the two-bit mode field to a mode code,
// an extension-word flag and any generated constant. Purely combinational.
module iwa_src_mode
    import iwa_pkg::*;
#(
    parameter int VAL_W = WORD_W
) (
    input  logic [3:0]       reg_num,
    input  logic [1:0]       as_bits,
    output amode_e           mode,
    output logic             needs_ext,
    output logic             cg_hit,
    output logic [VAL_W-1:0] cg_val
);
    // Mode selection, with special registers overriding the plain As meaning.
    always_comb begin
        cg_hit = 1'b0;
        cg_val = '0;
        unique case (as_bits)
            2'd0:    mode = AM_REG;
            2'd1:    mode = AM_IDX;
            2'd2:    mode = AM_IND;
            default: mode = AM_POST;
        endcase
        if (reg_num == 4'd0) begin
            if (as_bits == 2'd1) mode = AM_SYM;
            if (as_bits == 2'd2) mode = AM_BAD;
            if (as_bits == 2'd3) mode = AM_IMM;
        end else if (reg_num == 4'd2) begin
            if (as_bits == 2'd1) mode = AM_ABS;
            if (as_bits[1]) begin
                mode   = AM_CGEN;
                cg_hit = 1'b1;
                cg_val = as_bits[0] ? VAL_W'(8) : VAL_W'(4);
            end
        end else if (reg_num == 4'd3) begin
            mode   = AM_CGEN;
            cg_hit = 1'b1;
            cg_val = (as_bits == 2'd3) ? '1 : VAL_W'(as_bits);
        end
    end

    // Modes that carry an index, address or literal in the next word.
    assign needs_ext = (mode == AM_IDX) || (mode == AM_SYM) ||
                       (mode == AM_IMM) || (mode == AM_ABS);
endmodule

// File: rtl/iwa_dst_mode.sv
// Destination operand mode decoder for the two-operand class.
// Assumes the single mode bit and the register field of the first word.
module iwa_dst_mode
    import iwa_pkg::*;
(
    input  logic [3:0] reg_num,
    input  logic       ad_bit,
    output amode_e     mode,
    output logic       needs_ext
);
    // Register mode unless the mode bit is set; then registers 0 and 2 are special.
    always_comb begin
        if (!ad_bit)                mode = AM_REG;
        else if (reg_num == 4'd0)   mode = AM_SYM;
        else if (reg_num == 4'd2)   mode = AM_ABS;
        else                        mode = AM_IDX;
    end

    // Every memory destination carries one extension word.
    assign needs_ext = ad_bit;
endmodule

// File: rtl/iwa_word_decode.sv
// First-word classifier.
// Splits the format class, decodes both operand modes, the jump fields and
// the total instruction length. Combinational; the word is assumed stable.
module iwa_word_decode
    import iwa_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output dec_t              dec
);
    fmt_e              fmt;
    logic [3:0]        s_reg;
    amode_e            s_mode;
    amode_e            d_mode;
    logic              s_ext;
    logic              d_ext;
    logic              s_cg;
    logic [WORD_W-1:0] s_cgv;

    // Class from the top three bits; source register position depends on class.
    always_comb begin
        unique case (word[15:13])
            3'd0:    fmt = FMT_ONE;
            3'd1:    fmt = FMT_JMP;
            default: fmt = FMT_TWO;
        endcase
        s_reg = (fmt == FMT_TWO) ? word[11:8] : word[3:0];
    end

    iwa_src_mode #(.VAL_W(WORD_W)) u_src (
        .reg_num   (s_reg),
        .as_bits   (word[5:4]),
        .mode      (s_mode),
        .needs_ext (s_ext),
        .cg_hit    (s_cg),
        .cg_val    (s_cgv)
    );

    iwa_dst_mode u_dst (
        .reg_num   (word[3:0]),
        .ad_bit    (word[7]),
        .mode      (d_mode),
        .needs_ext (d_ext)
    );

    // Assemble the decoded fields per class.
    always_comb begin
        dec          = '0;
        dec.fmt      = fmt;
        dec.len      = 2'd1;
        dec.src_mode = AM_REG;
        dec.dst_mode = AM_REG;
        if (fmt == FMT_JMP) begin
            dec.cond   = word[12:10];
            dec.offset = {{(WORD_W-JOFF_W){word[JOFF_W-1]}}, word[JOFF_W-1:0]};
        end else begin
            dec.src_reg  = s_reg;
            dec.src_mode = s_mode;
            dec.cg_hit   = s_cg;
            dec.cg_val   = s_cgv;
            dec.bad      = (s_mode == AM_BAD);
            if (fmt == FMT_TWO) begin
                dec.dst_reg  = word[3:0];
                dec.dst_mode = d_mode;
            end
            if (!dec.bad)
                dec.len = 2'd1 + 2'(s_ext) + 2'((fmt == FMT_TWO) && d_ext);
        end
    end
endmodule

// File: rtl/insn_word_assembler.sv
// Variable-length instruction word assembler.
// Buffers up to three words, decodes the oldest one and, once its extension
// words are present (or it is invalid, or flush gives up on it), pops the
// consumed words and loads one record into a registered output slot.
// Assumes in_word is held while in_valid is high and not yet accepted.
module insn_word_assembler
    import iwa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_flush,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_word,
    output logic [1:0]        out_len,
    output logic              out_err,
    output logic [1:0]        out_fmt,
    output logic [3:0]        out_src_reg,
    output logic [3:0]        out_src_mode,
    output logic [3:0]        out_dst_reg,
    output logic [3:0]        out_dst_mode,
    output logic              out_cg_hit,
    output logic [WORD_W-1:0] out_cg_val,
    output logic [2:0]        out_cond,
    output logic [WORD_W-1:0] out_offset,
    output logic [WORD_W-1:0] out_ext0,
    output logic [WORD_W-1:0] out_ext1
);
    logic [WORD_W-1:0] buf_q [MAX_WORDS];
    logic [WORD_W-1:0] buf_d [MAX_WORDS];
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_d;
    logic [CNT_W-1:0]  pop;
    logic [CNT_W-1:0]  keep;
    dec_t              dec;
    logic              slot_free;
    logic              complete;
    logic              give_up;
    logic              fire;
    logic              push;
    logic              rec_err;

    iwa_word_decode u_dec (
        .word (buf_q[0]),
        .dec  (dec)
    );

    // Firing conditions for the oldest buffered instruction.
    assign slot_free = !out_valid || out_ready;
    assign complete  = CNT_W'(dec.len) <= cnt_q;
    assign give_up   = in_flush && !complete;
    assign fire      = (cnt_q != '0) && slot_free && (dec.bad || complete || give_up);
    assign rec_err   = dec.bad || !complete;

    // Input handshake: room in the buffer and no flush in progress.
    assign in_ready  = (cnt_q != CNT_W'(MAX_WORDS)) && !in_flush;
    assign push      = in_valid && in_ready;

    // Words removed this cycle: one on error, the full length otherwise.
    assign pop  = !fire ? '0 : (rec_err ? CNT_W'(1) : CNT_W'(dec.len));
    assign keep = cnt_q - pop;
    assign cnt_d = keep + CNT_W'(push);

    // Next buffer: shift out the popped words, append the accepted word.
    always_comb begin
        for (int i = 0; i < MAX_WORDS; i++) begin
            buf_d[i] = '0;
            for (int j = 0; j < MAX_WORDS; j++)
                if (j == i + int'(pop)) buf_d[i] = buf_q[j];
            if (push && (i == int'(keep))) buf_d[i] = in_word;
        end
    end

    // Buffer and occupancy registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < MAX_WORDS; i++) buf_q[i] <= '0;
        end else begin
            cnt_q <= cnt_d;
            for (int i = 0; i < MAX_WORDS; i++) buf_q[i] <= buf_d[i];
        end
    end

    // Output record slot: load on fire, release when taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_word     <= '0;
            out_len      <= '0;
            out_err      <= 1'b0;
            out_fmt      <= '0;
            out_src_reg  <= '0;
            out_src_mode <= '0;
            out_dst_reg  <= '0;
            out_dst_mode <= '0;
            out_cg_hit   <= 1'b0;
            out_cg_val   <= '0;
            out_cond     <= '0;
            out_offset   <= '0;
            out_ext0     <= '0;
            out_ext1     <= '0;
        end else if (fire) begin
            out_valid    <= 1'b1;
            out_word     <= buf_q[0];
            out_len      <= rec_err ? 2'd1 : dec.len;
            out_err      <= rec_err;
            out_fmt      <= dec.fmt;
            out_src_reg  <= dec.src_reg;
            out_src_mode <= dec.src_mode;
            out_dst_reg  <= dec.dst_reg;
            out_dst_mode <= dec.dst_mode;
            out_cg_hit   <= dec.cg_hit;
            out_cg_val   <= dec.cg_val;
            out_cond     <= dec.cond;
            out_offset   <= dec.offset;
            out_ext0     <= (!rec_err && dec.len >= 2'd2) ? buf_q[1] : '0;
            out_ext1     <= (!rec_err && dec.len == 2'd3) ? buf_q[2] : '0;
        end else if (out_ready) begin
            out_valid    <= 1'b0;
        end
    end
endmodule

// File: rtl/iwa_checker.sv
// Protocol and record-shape checks for the instruction word assembler.
// Bound to every instance of the top module; observes ports only.
module iwa_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_ready,
    input logic        in_flush,
    input logic        out_valid,
    input logic        out_ready,
    input logic [15:0] out_word,
    input logic [1:0]  out_len,
    input logic        out_err,
    input logic [1:0]  out_fmt,
    input logic [3:0]  out_src_mode,
    input logic        out_cg_hit,
    input logic [15:0] out_ext0,
    input logic [15:0] out_ext1
);
    // R10: a stalled record stays put.
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_word) &&
                                    $stable(out_len) && $stable(out_ext0) && $stable(out_ext1));

    // R10: no word is taken during flush.
    p_flush_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_flush |-> !in_ready);

    // R6: length is never zero and short records carry no extension data.
    p_len_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_len != 2'd0);
    p_short_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_len == 2'd1 |-> out_ext0 == 16'd0 && out_ext1 == 16'd0);

    // R8: error records consume exactly one word.
    p_err_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_err |-> out_len == 2'd1);

    // R7: jumps are one clean word.
    p_jump_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_fmt == 2'd1 |-> out_len == 2'd1 && !out_err);

    // R5: constant flag only with the constant source mode.
    p_cg_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_cg_hit |-> out_src_mode == 4'd7);
endmodule

bind insn_word_assembler iwa_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_ready     (in_ready),
    .in_flush     (in_flush),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_word     (out_word),
    .out_len      (out_len),
    .out_err      (out_err),
    .out_fmt      (out_fmt),
    .out_src_mode (out_src_mode),
    .out_cg_hit   (out_cg_hit),
    .out_ext0     (out_ext0),
    .out_ext1     (out_ext1)
);

// File: tb/insn_word_assembler_tb.sv
// Sweep bench: builds a word stream, predicts records from the requirements,
// and drives it under varying input gaps and output stalls.
module insn_word_assembler_tb;
    typedef struct packed {
        logic [15:0] word;
        logic [1:0]  len;
        logic        err;
        logic        trunc;
        logic [1:0]  fmt;
        logic [3:0]  sreg;
        logic [3:0]  smode;
        logic [3:0]  dreg;
        logic [3:0]  dmode;
        logic        cghit;
        logic [15:0] cgval;
        logic [2:0]  cond;
        logic [15:0] off;
        logic [15:0] ext0;
        logic [15:0] ext1;
    } rec_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_word = '0;
    logic        in_flush = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [15:0] out_word;
    logic [1:0]  out_len;
    logic        out_err;
    logic [1:0]  out_fmt;
    logic [3:0]  out_src_reg;
    logic [3:0]  out_src_mode;
    logic [3:0]  out_dst_reg;
    logic [3:0]  out_dst_mode;
    logic        out_cg_hit;
    logic [15:0] out_cg_val;
    logic [2:0]  out_cond;
    logic [15:0] out_offset;
    logic [15:0] out_ext0;
    logic [15:0] out_ext1;

    int n_chk = 0;
    int n_bad = 0;
    logic [16:0] stim[$];
    logic [15:0] pend[$];
    rec_t        exp_q[$];
    int          flush_tgt[$];
    logic [15:0] lfsr = 16'hACE1;
    int          ext_id = 0;

    always #10 clk = ~clk;

    insn_word_assembler u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .in_flush(in_flush), .out_valid(out_valid),
        .out_ready(out_ready), .out_word(out_word), .out_len(out_len),
        .out_err(out_err), .out_fmt(out_fmt), .out_src_reg(out_src_reg),
        .out_src_mode(out_src_mode), .out_dst_reg(out_dst_reg),
        .out_dst_mode(out_dst_mode), .out_cg_hit(out_cg_hit),
        .out_cg_val(out_cg_val), .out_cond(out_cond), .out_offset(out_offset),
        .out_ext0(out_ext0), .out_ext1(out_ext1)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected decode of a first word (R2..R8).
    function automatic rec_t model(input logic [15:0] w);
        rec_t r;
        int   s;
        int   as;
        int   need;
        r = '0;
        r.word = w;
        r.fmt = (w[15:13] == 3'd0) ? 2'd0 : (w[15:13] == 3'd1) ? 2'd1 : 2'd2;
        r.len = 2'd1;
        if (r.fmt == 2'd1) begin
            r.cond = w[12:10];
            r.off  = w[9] ? (16'hFC00 | 16'(w[9:0])) : 16'(w[9:0]);
            return r;
        end
        s  = (r.fmt == 2'd2) ? int'(w[11:8]) : int'(w[3:0]);
        as = int'(w[5:4]);
        r.sreg  = 4'(s);
        r.smode = 4'(as);
        if (s == 0 && as == 1) r.smode = 4'd4;
        if (s == 0 && as == 2) r.smode = 4'd15;
        if (s == 0 && as == 3) r.smode = 4'd5;
        if (s == 2 && as == 1) r.smode = 4'd6;
        if (s == 2 && as >= 2) begin r.smode = 4'd7; r.cghit = 1'b1; r.cgval = (as == 2) ? 16'd4 : 16'd8; end
        if (s == 3) begin r.smode = 4'd7; r.cghit = 1'b1; r.cgval = (as == 3) ? 16'hFFFF : 16'(as); end
        need = 1;
        if (r.smode == 4'd1 || r.smode == 4'd4 || r.smode == 4'd5 || r.smode == 4'd6) need++;
        if (r.fmt == 2'd2) begin
            r.dreg  = w[3:0];
            r.dmode = !w[7] ? 4'd0 : (w[3:0] == 4'd0) ? 4'd4 : (w[3:0] == 4'd2) ? 4'd6 : 4'd1;
            if (r.dmode != 4'd0) need++;
        end
        if (r.smode == 4'd15) begin r.err = 1'b1; need = 1; end
        r.len = 2'(need);
        return r;
    endfunction

    // Move every record the pending words allow into the expectation queue.
    task automatic drain(input bit fl);
        rec_t e;
        forever begin
            if (pend.size() == 0) break;
            e = model(pend[0]);
            if (e.err) begin
                exp_q.push_back(e);
                void'(pend.pop_front());
            end else if (pend.size() >= int'(e.len)) begin
                if (e.len >= 2'd2) e.ext0 = pend[1];
                if (e.len == 2'd3) e.ext1 = pend[2];
                exp_q.push_back(e);
                for (int k = 0; k < int'(e.len); k++) void'(pend.pop_front());
            end else if (fl) begin
                e.err = 1'b1; e.trunc = 1'b1; e.len = 2'd1;
                exp_q.push_back(e);
                void'(pend.pop_front());
            end else break;
        end
    endtask

    task automatic add_word(input logic [15:0] w);
        stim.push_back({1'b0, w});
        pend.push_back(w);
        drain(1'b0);
    endtask

    task automatic add_flush();
        stim.push_back(17'h10000);
        drain(1'b1);
        flush_tgt.push_back(exp_q.size());
    endtask

    // Add an instruction followed by exactly the extension words it needs.
    task automatic add_insn(input logic [15:0] w);
        rec_t e;
        e = model(w);
        add_word(w);
        for (int k = 1; k < int'(e.len); k++) begin
            ext_id++;
            add_word(16'hC000 | 16'(ext_id));
        end
    endtask

    task automatic cmp_rec(input rec_t e);
        chk(out_word == e.word, "R11 order", 32'(out_word), 32'(e.word));
        chk(out_len == e.len, "R6 length", 32'(out_len), 32'(e.len));
        chk(out_ext0 == e.ext0, "R6 ext0", 32'(out_ext0), 32'(e.ext0));
        chk(out_ext1 == e.ext1, "R6 ext1", 32'(out_ext1), 32'(e.ext1));
        chk(out_fmt == e.fmt, "R2 class", 32'(out_fmt), 32'(e.fmt));
        chk(out_src_reg == e.sreg && out_dst_reg == e.dreg, "R2 regs",
            {out_src_reg, out_dst_reg}, {e.sreg, e.dreg});
        chk(out_src_mode == e.smode, "R3 src mode", 32'(out_src_mode), 32'(e.smode));
        chk(out_dst_mode == e.dmode, "R4 dst mode", 32'(out_dst_mode), 32'(e.dmode));
        chk(out_cg_hit == e.cghit && out_cg_val == e.cgval, "R5 constant",
            {out_cg_hit, out_cg_val}, {e.cghit, e.cgval});
        chk(out_cond == e.cond && out_offset == e.off, "R7 jump",
            {out_cond, out_offset}, {e.cond, e.off});
        chk(out_err == e.err, e.trunc ? "R9 truncation error" : "R8 error flag",
            32'(out_err), 32'(e.err));
    endtask

    initial begin
        int si;
        int got;
        int total;
        int cyc;
        int fl_cyc;
        int sel;
        rec_t e;

        // Stream construction: two-operand sweep over all class codes 2..7.
        for (int s = 0; s < 16; s++)
            for (int as = 0; as < 4; as++)
                for (int ad = 0; ad < 2; ad++)
                    for (int di = 0; di < 4; di++) begin
                        logic [3:0] d;
                        logic [2:0] top;
                        d   = (di == 0) ? 4'd0 : (di == 1) ? 4'd2 : (di == 2) ? 4'd3 : 4'd9;
                        top = 3'(2 + ((s * 8 + as * 2 + ad + di) % 6));
                        add_insn({top, 1'b0, 4'(s), 1'(ad), 1'b0, 2'(as), d});
                    end
        // Single-operand sweep.
        for (int r = 0; r < 16; r++)
            for (int as = 0; as < 4; as++)
                add_insn(16'h1000 | 16'(as << 4) | 16'(r));
        // Jump sweep with offsets around the sign boundary.
        for (int c = 0; c < 8; c++)
            for (int oi = 0; oi < 5; oi++) begin
                logic [9:0] o;
                o = (oi == 0) ? 10'h000 : (oi == 1) ? 10'h001 : (oi == 2) ? 10'h1FF :
                    (oi == 3) ? 10'h200 : 10'h3FF;
                add_insn(16'h2000 | 16'(c << 10) | 16'(o));
            end
        add_flush();
        add_flush();                                          // R9 empty flush
        add_word(16'h4596); add_word(16'h1234); add_flush();  // R9 replay complete word
        add_word(16'h4596); add_word(16'h4016); add_flush();  // R9 replay incomplete word
        add_word(16'h4016); add_flush();                      // R9 one short
        add_word(16'h4596); add_word(16'h2155); add_flush();  // R9 replay jump
        add_insn(16'h4020); add_insn(16'h4596); add_flush();  // R8 invalid then normal
        total = exp_q.size();

        // R1 reset state.
        out_ready = 1'b1;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 reset out_valid", 32'(out_valid), 0);
        chk(in_ready == 1'b1, "R1 reset in_ready", 32'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk); in_valid = 1'b1; in_word = 16'h4596;
        @(negedge clk); in_word = 16'hAAAA;
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R6 incomplete holds", 32'(out_valid), 0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(out_valid == 1'b0, "R1 reset clears", 32'(out_valid), 0);
        chk(in_ready == 1'b1, "R1 reset empties buffer", 32'(in_ready), 1);

        // Main run.
        si = 0; got = 0; cyc = 0; fl_cyc = 0;
        while (!(si == stim.size() && got == total)) begin
            @(negedge clk);
            cyc++;
            if (cyc > 100000) begin
                chk(1'b0, "R10 watchdog", 32'(got), 32'(total));
                break;
            end
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            sel  = (si / 150) % 3;
            out_ready = (sel == 0) ? 1'b1 : (sel == 1) ? lfsr[3] : (lfsr[4] & lfsr[5]);
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) chk(1'b0, "R10 extra record", 32'(out_word), 0);
                else begin
                    e = exp_q.pop_front();
                    cmp_rec(e);
                end
                got++;
            end
            if (si < stim.size()) begin
                if (stim[si][16]) begin
                    in_valid = 1'b0;
                    if (fl_cyc > 0 && got >= flush_tgt[0]) begin
                        in_flush = 1'b0;
                        fl_cyc = 0;
                        void'(flush_tgt.pop_front());
                        si++;
                    end else begin
                        in_flush = 1'b1;
                        fl_cyc++;
                        #1;
                        if (fl_cyc == 1) chk(in_ready == 1'b0, "R10 flush blocks input", 32'(in_ready), 0);
                    end
                end else begin
                    in_flush = 1'b0;
                    in_word  = stim[si][15:0];
                    in_valid = (sel == 0) ? 1'b1 : (sel == 1) ? lfsr[0] : (lfsr[1] | lfsr[2]);
                    #1;
                    if (in_valid && in_ready) si++;
                end
            end else begin
                in_valid = 1'b0;
                in_flush = 1'b0;
            end
        end
        @(negedge clk);
        out_ready = 1'b0;
        in_valid  = 1'b0;
        chk(got == total && exp_q.size() == 0, "R10 record count", 32'(got), 32'(total));
        chk(out_valid == 1'b0, "R11 no stray record", 32'(out_valid), 0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule